// File: doc/BRIEF.md
# Compare-Value Timer Channel

This block is a single channel of a system timer. A free-running 64-bit count arrives on an input port. The channel subtracts an optional offset from it to get an elapsed value, and compares that result against a stored 64-bit compare value. When the channel is enabled and the elapsed value has reached the compare value, a status flag is set. The status flag drives a level interrupt unless the interrupt is masked.

Software reaches the channel through a simple register port: one write strobe with an address and data, and a separate combinational read address and data path. Four registers are visible:

- a compare value;
- a signed 32-bit down-count view, whose writes are turned into compare-value updates relative to the current elapsed value;
- a control register holding enable, mask and a read-only status bit;
- an offset register, which exists only when the channel is built as the virtual variant.

Top module: `cmp_timer`

## Requirements
- R1: The control register (address 2) holds enable in bit 0, interrupt mask in bit 1 and status in bit 2, and reads zero above bit 2. Writes change only bits 1:0; data in bit 2 and above has no effect.
- R2: While enabled, status is recomputed at every clock edge as the unsigned 64-bit wrap-around comparison (count_i − offset) ≥ compare value. It uses count_i as sampled at that edge, so it appears one clock after the count changes.
- R3: irq_o is high only when enable is 1, status is 1 and mask is 0.
- R4: While disabled, status reads 0 and irq_o is low.
- R5: A write to the down-count view (address 1) sets the compare value to (count_i − offset) plus wr_data[31:0] sign-extended to 64 bits.
- R6: A write to the compare value, to the offset, or to control that changes enable re-evaluates status and interrupt at that same clock edge, using the newly written values.
- R7: A control write whose bit 0 equals the current enable is treated as a mask-only change. At that edge status keeps its old value and irq_o becomes (old status) AND NOT (new mask). Full recomputation resumes at the next edge.
- R8: The offset (address 3) is writable and readable only in the virtual variant (HAS_OFFS=1). In the physical variant it reads 0, writes to it are ignored, and the elapsed value equals count_i.
- R9: Reading address 1 returns, zero-extended, the low 32 bits of (compare value − (count_i − offset)), using the live count_i.
- R10: Reset clears compare value, offset, enable, mask and status, and drives irq_o low.
- R11: Reading address 0 returns the compare value; rd_data follows rd_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 64 | Free-running system count |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 compare, 1 down-count, 2 control, 3 offset |
| wr_data | input | 64 | Write data |
| rd_addr | input | 2 | Read address, same map as wr_addr |
| rd_data | output | 64 | Read data |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions check four things on every cycle:

- the interrupt is gated by enable, mask and status;
- disable forces status and interrupt low;
- after a cycle without a write, status equals the unsigned elapsed-versus-compare result;
- a down-count write loads the sign-extended compare value, and a mask-only control write holds status and applies the new mask.

Only the bench scenarios show the behaviours that depend on stimulus order. These include the wrap-around comparison with a large offset, and a mask-only write landing on the very cycle the count crosses the compare value. They also include the read-only status bit, the live down-count readback, and the difference between the virtual and physical variants driven from the same inputs.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CVAL = 2'd0,
        ADDR_TVAL = 2'd1,
        ADDR_CTRL = 2'd2,
        ADDR_OFFS = 2'd3
    } tmr_addr_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MASK_BIT = 1;
    localparam int CTRL_STAT_BIT = 2;
endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter int TV_W     = 32,
    parameter int HAS_OFFS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [CNT_W-1:0]  elapsed_q,
    output logic [CNT_W-1:0]  cval_d,
    output logic [CNT_W-1:0]  cval_q,
    output logic [CNT_W-1:0]  offs_d,
    output logic [CNT_W-1:0]  offs_q,
    output logic              en_d,
    output logic              en_q,
    output logic              mask_d,
    output logic              mask_q,
    output logic              hold_d
);
    localparam int EXT_W = CNT_W - TV_W;

    typedef struct packed {
        logic [CNT_W-1:0] cval;
        logic [CNT_W-1:0] offs;
        logic             en;
        logic             mask;
    } reg_t;

    reg_t cur_q, nxt_d;
    logic hold_c;
    logic [CNT_W-1:0] tv_ext;

    assign tv_ext = {{EXT_W{wr_data[TV_W-1]}}, wr_data[TV_W-1:0]};

    always_comb begin
        nxt_d  = cur_q;
        hold_c = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                ADDR_CVAL: nxt_d.cval = wr_data;
                ADDR_TVAL: nxt_d.cval = elapsed_q + tv_ext;
                ADDR_CTRL: begin
                    nxt_d.en   = wr_data[CTRL_EN_BIT];
                    nxt_d.mask = wr_data[CTRL_MASK_BIT];
                    hold_c     = (wr_data[CTRL_EN_BIT] == cur_q.en);
                end
                ADDR_OFFS: nxt_d.offs = (HAS_OFFS != 0) ? wr_data : '0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cval_d = nxt_d.cval;
    assign cval_q = cur_q.cval;
    assign offs_d = nxt_d.offs;
    assign offs_q = cur_q.offs;
    assign en_d   = nxt_d.en;
    assign en_q   = cur_q.en;
    assign mask_d = nxt_d.mask;
    assign mask_q = cur_q.mask;
    assign hold_d = hold_c;
endmodule

// File: rtl/cmp_timer_cmp.sv
module cmp_timer_cmp #(
    parameter int CNT_W = 64
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] offs,
    input  logic [CNT_W-1:0] cval,
    output logic             reached
);
    logic [CNT_W-1:0] elapsed;
    assign elapsed = count_i - offs;
    assign reached = (elapsed >= cval);
endmodule

// File: rtl/cmp_timer_stat.sv
module cmp_timer_stat (
    input  logic clk,
    input  logic rst_n,
    input  logic en_d,
    input  logic mask_d,
    input  logic reached_d,
    input  logic hold_d,
    output logic status_q,
    output logic irq_q
);
    typedef struct packed {
        logic status;
        logic irq;
    } stat_t;

    stat_t cur_q, nxt_d;

    always_comb begin
        if (hold_d) begin
            nxt_d.status = cur_q.status;
            nxt_d.irq    = cur_q.status & ~mask_d;
        end else begin
            nxt_d.status = en_d & reached_d;
            nxt_d.irq    = en_d & reached_d & ~mask_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign status_q = cur_q.status;
    assign irq_q    = cur_q.irq;
endmodule

// File: rtl/cmp_timer_view.sv
module cmp_timer_view
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter int TV_W     = 32,
    parameter int HAS_OFFS = 1
) (
    input  logic [CNT_W-1:0]  count_i,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  cval_q,
    input  logic [CNT_W-1:0]  offs_q,
    input  logic              en_q,
    input  logic              mask_q,
    input  logic              status_q,
    output logic [CNT_W-1:0]  elapsed_q,
    output logic [CNT_W-1:0]  rd_data
);
    logic [TV_W-1:0] remain_lo;

    assign elapsed_q = count_i - offs_q;
    assign remain_lo = cval_q[TV_W-1:0] - elapsed_q[TV_W-1:0];

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_CVAL: rd_data = cval_q;
            ADDR_TVAL: rd_data[TV_W-1:0] = remain_lo;
            ADDR_CTRL: begin
                rd_data[CTRL_EN_BIT]   = en_q;
                rd_data[CTRL_MASK_BIT] = mask_q;
                rd_data[CTRL_STAT_BIT] = status_q;
            end
            ADDR_OFFS: rd_data = (HAS_OFFS != 0) ? offs_q : '0;
            default: ;
        endcase
    end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter int TV_W     = 32,
    parameter int HAS_OFFS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq_o
);
    logic [CNT_W-1:0] cval_d, cval_q, offs_d, offs_q, elapsed_q;
    logic en_d, en_q, mask_d, mask_q, hold_d, reached_d, status_q;

    cmp_timer_regs #(.CNT_W(CNT_W), .TV_W(TV_W), .HAS_OFFS(HAS_OFFS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .elapsed_q(elapsed_q),
        .cval_d(cval_d), .cval_q(cval_q), .offs_d(offs_d), .offs_q(offs_q),
        .en_d(en_d), .en_q(en_q), .mask_d(mask_d), .mask_q(mask_q),
        .hold_d(hold_d)
    );

    cmp_timer_cmp #(.CNT_W(CNT_W)) u_cmp (
        .count_i(count_i), .offs(offs_d), .cval(cval_d), .reached(reached_d)
    );

    cmp_timer_stat u_stat (
        .clk(clk), .rst_n(rst_n), .en_d(en_d), .mask_d(mask_d),
        .reached_d(reached_d), .hold_d(hold_d),
        .status_q(status_q), .irq_q(irq_o)
    );

    cmp_timer_view #(.CNT_W(CNT_W), .TV_W(TV_W), .HAS_OFFS(HAS_OFFS)) u_view (
        .count_i(count_i), .rd_addr(rd_addr), .cval_q(cval_q), .offs_q(offs_q),
        .en_q(en_q), .mask_q(mask_q), .status_q(status_q),
        .elapsed_q(elapsed_q), .rd_data(rd_data)
    );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W    = 64,
    parameter int TV_W     = 32,
    parameter int HAS_OFFS = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  count_i,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              irq_o,
    input logic              en_q,
    input logic              mask_q,
    input logic              status_q,
    input logic [CNT_W-1:0]  cval_q,
    input logic [CNT_W-1:0]  offs_q
);
    function automatic logic [CNT_W-1:0] sx(input logic [CNT_W-1:0] v);
        return {{(CNT_W-TV_W){v[TV_W-1]}}, v[TV_W-1:0]};
    endfunction

    // R3
    p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en_q && !mask_q && status_q));

    // R4
    p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!status_q && !irq_o));

    // R2
    p_status_cmp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en)) |->
        (status_q == (en_q && (($past(count_i) - offs_q) >= cval_q))));

    // R5
    p_tval_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && ($past(wr_addr) == ADDR_TVAL)) |->
        (cval_q == ($past(count_i) - $past(offs_q) + sx($past(wr_data)))));

    // R7
    p_hold_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && ($past(wr_addr) == ADDR_CTRL) &&
         ($past(wr_data[CTRL_EN_BIT]) == $past(en_q))) |->
        ((status_q == $past(status_q)) && (irq_o == ($past(status_q) && !mask_q))));

    // R8
    p_phys_offs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_OFFS == 0) |-> (offs_q == '0));
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W), .TV_W(TV_W), .HAS_OFFS(HAS_OFFS)) u_chk (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq_o(irq_o),
    .en_q(en_q), .mask_q(mask_q), .status_q(status_q),
    .cval_q(cval_q), .offs_q(offs_q)
);

// File: tb/cmp_timer_tb.sv
`timescale 1ns/1ps
module cmp_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] count_i = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [63:0] rd_v, rd_p;
    logic        irq_v, irq_p;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    longint unsigned m_cval[2], m_off[2];
    bit m_en[2], m_mask[2], m_stat[2], m_irq[2];

    always #2 clk = ~clk;

    cmp_timer #(.HAS_OFFS(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_v), .irq_o(irq_v));

    cmp_timer #(.HAS_OFFS(0)) u_dut_phys (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_p), .irq_o(irq_p));

    function automatic longint unsigned sx32(longint unsigned d);
        return {{32{d[31]}}, d[31:0]};
    endfunction

    task automatic check(string tag, longint unsigned act, longint unsigned exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_cval[i] = 0; m_off[i] = 0; m_en[i] = 0;
            m_mask[i] = 0; m_stat[i] = 0; m_irq[i] = 0;
        end
    endtask

    task automatic model_edge();
        for (int i = 0; i < 2; i++) begin
            longint unsigned cv = m_cval[i];
            longint unsigned of = m_off[i];
            bit en = m_en[i];
            bit mk = m_mask[i];
            bit hold = 0;
            if (wr_en) begin
                case (wr_addr)
                    2'd0: cv = wr_data;
                    2'd1: cv = (count_i - m_off[i]) + sx32(wr_data);
                    2'd2: begin
                        en = wr_data[0]; mk = wr_data[1];
                        hold = (wr_data[0] == m_en[i]);
                    end
                    default: if (i == 0) of = wr_data;
                endcase
            end
            if (hold) begin
                m_irq[i] = m_stat[i] && !mk;
            end else begin
                m_stat[i] = en && ((count_i - of) >= cv);
                m_irq[i]  = m_stat[i] && !mk;
            end
            m_cval[i] = cv; m_off[i] = of; m_en[i] = en; m_mask[i] = mk;
        end
    endtask

    function automatic longint unsigned exp_rd(int i, int a);
        longint unsigned r;
        case (a)
            0: return m_cval[i];
            1: begin r = m_cval[i] - (count_i - m_off[i]); return {32'd0, r[31:0]}; end
            2: return {61'd0, m_stat[i], m_mask[i], m_en[i]};
            default: return (i == 0) ? m_off[i] : 0;
        endcase
    endfunction

    task automatic compare_all(string tag);
        string rt;
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #0.2;
            case (a)
                0: rt = "R11 cval";
                1: rt = "R9 tval";
                2: rt = "R1 ctrl";
                default: rt = "R8 offs";
            endcase
            check({tag, " ", rt, " virt"}, rd_v, exp_rd(0, a));
            check({tag, " ", rt, " phys"}, rd_p, exp_rd(1, a));
        end
        check({tag, " R3 irq virt"}, 64'(irq_v), 64'(m_irq[0]));
        check({tag, " R3 irq phys"}, 64'(irq_p), 64'(m_irq[1]));
    endtask

    task automatic step(string tag, bit we, int addr, longint unsigned data,
                        longint unsigned cnt);
        count_i = cnt;
        wr_en   = we;
        wr_addr = 2'(addr);
        wr_data = data;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
        wr_en = 1'b0;
    endtask

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        longint unsigned c;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare_all("R10 reset");
        step("R10 idle", 0, 0, 0, 0);
        step("R6 cval", 1, 0, 100, 50);
        step("R6 enable", 1, 2, 1, 60);
        step("R2 below", 0, 0, 0, 99);
        step("R2 equal", 0, 0, 0, 100);
        step("R7 mask on", 1, 2, 3, 101);
        step("R7 mask off", 1, 2, 1, 102);
        step("R4 disable", 1, 2, 0, 103);
        step("R4 stays low", 0, 0, 0, 150);
        step("R1 ro bit2", 1, 2, 64'h4, 104);
        step("R1 ro high", 1, 2, 64'hFFFF_FFFF_FFFF_FFF5, 105);
        step("R5 tval pos", 1, 1, 64'hDEAD_BEEF_0000_0010, 200);
        step("R9 read", 0, 0, 0, 210);
        step("R5 tval neg", 1, 1, 64'h0000_0000_FFFF_FFF0, 300);
        step("R8 offs write", 1, 3, 1000, 300);
        step("R8 cval", 1, 0, 64'h1000, 5000);
        step("R2 wrap max", 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 500);
        step("R2 wrap hit", 1, 3, 501, 500);
        step("R6 offs clear", 1, 3, 0, 0);
        step("R6 cval load", 1, 0, 1000, 10);
        step("R7 setup", 1, 2, 3, 20);
        step("R7 cross", 1, 2, 1, 1000);
        step("R7 after", 0, 0, 0, 1001);
        step("R5 tval wrap", 1, 1, 64'h8000_0000, 64'h0000_0001_0000_0000);
        c = 64'h0000_0000_7FFF_FFF0;
        for (int i = 0; i < 40; i++) begin
            c = c + 64'd7;
            step("R2 run", 0, 0, 0, c);
        end
        step("R4 final off", 1, 2, 2, c);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule